// File: doc/BRIEF.md
# Ethernet MAC Host Register Block

This block is the processor side of a small Ethernet MAC. It provides the registers and the interrupt logic, and it sits between a simple synchronous read/write bus and the transmit and receive engines. Software uses it to load the station address. It writes the byte count of an outgoing frame and then fires the transmitter with a command write. It learns that a frame has arrived from the status register. After reading that frame, it re-arms the receiver with a second command bit.

The engines report completion with single-cycle pulses. The block keeps a sticky flag for each completion and a readiness bit for each direction. Each flag is gated by its own enable bit, and the gated flags are combined into one registered, active-high interrupt. Any read of the status register clears both flags. The start commands are one-cycle pulses. A transmit start is refused while a frame is still in flight, so a frame that has begun can never be corrupted by a new command.

Top module: `mac_host_regs`

## Requirements
- R1: The station address is held as six bytes. Word 0 bits [7:0] hold the first (most significant) address byte, and [15:8], [23:16] and [31:24] hold the second, third and fourth bytes. Word 1 bits [7:0] and [15:8] hold the fifth and sixth bytes. `station_addr` presents them in natural order, with the first byte in bits [47:40]. Both words read back as written, and word 1 reads zero above bit 15.
- R2: A write to word 2 with bit 0 set while the transmitter is ready raises `tx_start` for one cycle after that clock edge and clears the ready bit. A `tx_done` pulse sets the ready bit again.
- R3: A write to word 2 with bit 1 set raises `rx_start` for one cycle and clears the frame-held bit. An `rx_done` pulse sets the frame-held bit and captures `rx_len_in` into word 6. When both occur in the same cycle, `rx_done` wins.
- R4: Word 2 always reads zero. Each start output stays high for no more than one cycle.
- R5: A transmit start written while the transmitter is not ready is ignored. No pulse appears and the ready bit stays low.
- R6: Word 3 reads as follows: bit 0 is transmitter ready, bit 1 is frame held, bit 2 is the sticky transmit-done flag and bit 3 is the sticky receive-done flag. Any read of word 3 clears both flags at that clock edge. A done pulse in the same cycle as the read keeps its flag set.
- R7: Word 4 bits [1:0] are the interrupt enables. Bit 0 gates the transmit flag and bit 1 gates the receive flag. `irq` is a register that follows the OR of the enabled flags one clock later.
- R8: Word 5 holds an 11-bit transmit length. It reads back masked to 11 bits and drives `tx_len`. Word 6 is read-only, and writes to it have no effect.
- R9: A synchronous active-low reset clears every register and `irq`, except the transmitter-ready bit, which resets to one. After reset, word 3 therefore reads 1.
- R10: Reads are combinational from `bus_addr` (a word index). Writes and read side effects take place on the rising edge of `clk` while `bus_sel` is high. `bus_wr` selects a write. Word 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| station_addr | output | 48 | Station address, first byte in [47:40] |
| tx_start | output | 1 | One-cycle transmit start |
| tx_len | output | 11 | Frame byte count for the transmitter |
| tx_done | input | 1 | Transmit completion pulse |
| rx_start | output | 1 | One-cycle receiver re-arm |
| rx_done | input | 1 | Receive completion pulse |
| rx_len_in | input | 11 | Byte count of the received frame |
| irq | output | 1 | Registered interrupt, active high |

## Verification
On every cycle, the checker covers the following:
- the width of the start pulses;
- the refusal of a transmit start while the transmitter is busy;
- the effect of the done pulses on the ready and frame-held bits;
- the clearing of the flags on a status read, with a concurrent done pulse winning;
- the one-cycle registered relation between the enabled flags and `irq`.

Other behaviour can only be shown by the bench's scenarios. This includes the byte order of the station address, the masking of readback widths, the read-only length word and the reset values after a mid-run reset.

// File: rtl/mac_regs_pkg.sv
// Package: shared constants and register word indices for the MAC host
// register block. Assumes a 32-bit bus and an 8-word register window.
package mac_regs_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int LEN_W    = 11;
    localparam int MAC_B    = 6;
    localparam int MAC_W    = MAC_B * 8;
    localparam int IRQ_SRC  = 2;

    typedef enum logic [ADDR_W-1:0] {
        W_ADDR_LO = 3'd0,
        W_ADDR_HI = 3'd1,
        W_CMD     = 3'd2,
        W_STATUS  = 3'd3,
        W_IRQ_EN  = 3'd4,
        W_TX_LEN  = 3'd5,
        W_RX_LEN  = 3'd6,
        W_SPARE   = 3'd7
    } reg_word_e;

    // Index of each source within the flag and enable vectors.
    localparam int SRC_TX = 0;
    localparam int SRC_RX = 1;
endpackage

// File: rtl/mac_station_addr.sv
// Module: station address store.
// Holds six address bytes written through two bus words. Byte k of the
// register space is address byte k, where byte 0 is the most significant
// byte. The address is presented in natural order on station_addr.
// Assumes: write strobes are one cycle and already decoded by the parent.
module mac_station_addr
    import mac_regs_pkg::*;
#(
    parameter int BYTES = MAC_B
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_lo,
    output logic [DATA_W-1:0]   rd_hi,
    output logic [BYTES*8-1:0]  station_addr
);
    localparam int LO_BYTES = DATA_W / 8;
    localparam int HI_BYTES = BYTES - LO_BYTES;

    logic [7:0] byte_q [BYTES];

    genvar k;
    generate
        for (k = 0; k < BYTES; k++) begin : g_byte
            if (k < LO_BYTES) begin : g_lo
                // Capture one low-word byte on a write to the low word.
                always_ff @(posedge clk) begin
                    if (!rst_n)     byte_q[k] <= '0;
                    else if (wr_lo) byte_q[k] <= wdata[8*k +: 8];
                end
                assign rd_lo[8*k +: 8] = byte_q[k];
            end else begin : g_hi
                // Capture one high-word byte on a write to the high word.
                always_ff @(posedge clk) begin
                    if (!rst_n)     byte_q[k] <= '0;
                    else if (wr_hi) byte_q[k] <= wdata[8*(k-LO_BYTES) +: 8];
                end
                assign rd_hi[8*(k-LO_BYTES) +: 8] = byte_q[k];
            end
            // Byte 0 is the most significant byte of the natural address.
            assign station_addr[(BYTES-1-k)*8 +: 8] = byte_q[k];
        end
    endgenerate

    assign rd_hi[DATA_W-1:HI_BYTES*8] = '0;
endmodule

// File: rtl/mac_cmd_ctrl.sv
// Module: command and engine-state control.
// Turns command writes into one-cycle start pulses and tracks the
// transmitter-ready and frame-held bits. A transmit start is refused while
// the transmitter is busy. An rx_done in the same cycle as a receive
// re-arm leaves the frame-held bit set.
// Assumes: tx_done and rx_done are one-cycle pulses from the engines.
module mac_cmd_ctrl
    import mac_regs_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          cmd_tx,
    input  logic          cmd_rx,
    input  logic          tx_done,
    input  logic          rx_done,
    input  logic [LW-1:0] rx_len_in,
    output logic          tx_start,
    output logic          rx_start,
    output logic          txr,
    output logic          rxv,
    output logic [LW-1:0] rx_len
);
    logic go_tx, go_rx;

    // Decode accepted starts from the command write and the current state.
    always_comb begin
        go_tx = cmd_wr && cmd_tx && txr;
        go_rx = cmd_wr && cmd_rx;
    end

    // Issue the registered single-cycle start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_start <= 1'b0;
            rx_start <= 1'b0;
        end else begin
            tx_start <= go_tx;
            rx_start <= go_rx;
        end
    end

    // Track transmitter readiness; an accepted start takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       txr <= 1'b1;
        else if (go_tx)   txr <= 1'b0;
        else if (tx_done) txr <= 1'b1;
    end

    // Track the frame-held bit; a completed frame takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       rxv <= 1'b0;
        else if (rx_done) rxv <= 1'b1;
        else if (go_rx)   rxv <= 1'b0;
    end

    // Capture the byte count of each completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_len <= '0;
        else if (rx_done) rx_len <= rx_len_in;
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
// Module: sticky completion flags and the interrupt output.
// Each completion pulse sets its own flag. A status read clears all flags,
// but a pulse in the same cycle wins. irq is registered from the enabled
// flags, so it lags them by one clock and cannot glitch.
// Assumes: stat_rd is high for exactly the cycles of a status-word read.
module mac_irq_ctrl
    import mac_regs_pkg::*;
#(
    parameter int NSRC = IRQ_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] done,
    input  logic            stat_rd,
    input  logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] flags,
    output logic            irq
);
    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            // Set on completion, clear on status read, with set winning.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags[s] <= 1'b0;
                else if (done[s]) flags[s] <= 1'b1;
                else if (stat_rd) flags[s] <= 1'b0;
            end
        end
    endgenerate

    // Register the OR of the enabled flags onto the interrupt pin.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & enable);
    end
endmodule

// File: rtl/mac_host_regs.sv
// Module: top of the MAC host register block.
// Decodes the bus, holds the enable and transmit-length words, muxes
// read data, and joins the address store, command control and interrupt
// logic. Reads are combinational; writes and the status-read side effect
// take place on the rising clock edge while bus_sel is high.
// Assumes: a single master that keeps bus_sel high for one cycle per access.
module mac_host_regs
    import mac_regs_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [MAC_W-1:0]  station_addr,
    output logic              tx_start,
    output logic [LW-1:0]     tx_len,
    input  logic              tx_done,
    output logic              rx_start,
    input  logic              rx_done,
    input  logic [LW-1:0]     rx_len_in,
    output logic              irq
);
    logic wr_lo, wr_hi, cmd_wr, en_wr, len_wr, stat_rd;
    logic [DATA_W-1:0]  rd_lo, rd_hi;
    logic               txr, rxv;
    logic [LW-1:0]      rx_len;
    logic [IRQ_SRC-1:0] irq_en_q, flags, done_vec;

    // Decode one strobe per word from the bus.
    always_comb begin
        wr_lo   = bus_sel &&  bus_wr && (bus_addr == W_ADDR_LO);
        wr_hi   = bus_sel &&  bus_wr && (bus_addr == W_ADDR_HI);
        cmd_wr  = bus_sel &&  bus_wr && (bus_addr == W_CMD);
        en_wr   = bus_sel &&  bus_wr && (bus_addr == W_IRQ_EN);
        len_wr  = bus_sel &&  bus_wr && (bus_addr == W_TX_LEN);
        stat_rd = bus_sel && !bus_wr && (bus_addr == W_STATUS);
    end

    // Hold the interrupt enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_en_q <= '0;
        else if (en_wr) irq_en_q <= bus_wdata[IRQ_SRC-1:0];
    end

    // Hold the transmit byte count.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_len <= '0;
        else if (len_wr) tx_len <= bus_wdata[LW-1:0];
    end

    // Select read data by word index; the command word reads zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            W_ADDR_LO: bus_rdata = rd_lo;
            W_ADDR_HI: bus_rdata = rd_hi;
            W_STATUS:  bus_rdata = {{(DATA_W-4){1'b0}}, flags[SRC_RX], flags[SRC_TX], rxv, txr};
            W_IRQ_EN:  bus_rdata = {{(DATA_W-IRQ_SRC){1'b0}}, irq_en_q};
            W_TX_LEN:  bus_rdata = {{(DATA_W-LW){1'b0}}, tx_len};
            W_RX_LEN:  bus_rdata = {{(DATA_W-LW){1'b0}}, rx_len};
            default:   bus_rdata = '0;
        endcase
    end

    // Gather the completion pulses in flag order.
    always_comb begin
        done_vec         = '0;
        done_vec[SRC_TX] = tx_done;
        done_vec[SRC_RX] = rx_done;
    end

    mac_station_addr #(.BYTES(MAC_B)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi),
        .wdata        (bus_wdata),
        .rd_lo        (rd_lo),
        .rd_hi        (rd_hi),
        .station_addr (station_addr)
    );

    mac_cmd_ctrl #(.LW(LW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_tx    (bus_wdata[0]),
        .cmd_rx    (bus_wdata[1]),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .rx_len_in (rx_len_in),
        .tx_start  (tx_start),
        .rx_start  (rx_start),
        .txr       (txr),
        .rxv       (rxv),
        .rx_len    (rx_len)
    );

    mac_irq_ctrl #(.NSRC(IRQ_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done_vec),
        .stat_rd (stat_rd),
        .enable  (irq_en_q),
        .flags   (flags),
        .irq     (irq)
    );
endmodule

// File: rtl/mac_host_regs_chk.sv
// Module: cycle-level checker for mac_host_regs, attached by bind.
// Assumes: connected to the top's ports and its internal state nets.
module mac_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_start,
    input logic       rx_start,
    input logic       tx_done,
    input logic       rx_done,
    input logic       irq,
    input logic       txr,
    input logic       rxv,
    input logic [1:0] flags,
    input logic [1:0] irq_en,
    input logic       cmd_wr,
    input logic [1:0] cmd_bits,
    input logic       stat_rd
);
    assert_tx_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[0] && txr) |=> (tx_start && !txr));
    assert_txdone_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !(cmd_wr && cmd_bits[0])) |=> txr);
    assert_rx_done_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rxv);
    assert_rx_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[1] && !rx_done) |=> (rx_start && !rxv));
    assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start);
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[0] && !txr) |=> (!tx_start && !txr));
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tx_done && !rx_done) |=> (flags == 2'b00));
    assert_done_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> flags[0]);
    assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(flags & irq_en))));
endmodule

bind mac_host_regs mac_host_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_start (tx_start),
    .rx_start (rx_start),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .irq      (irq),
    .txr      (txr),
    .rxv      (rxv),
    .flags    (flags),
    .irq_en   (irq_en_q),
    .cmd_wr   (cmd_wr),
    .cmd_bits (bus_wdata[1:0]),
    .stat_rd  (stat_rd)
);

// File: tb/tb_mac_host_regs.sv
// Bench for mac_host_regs: a write/readback vector table, then directed
// scenarios for the engines, the interrupts and reset.
module tb_mac_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] station_addr;
    logic        tx_start, rx_start, irq;
    logic [10:0] tx_len;
    logic        tx_done = 1'b0, rx_done = 1'b0;
    logic [10:0] rx_len_in = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    mac_host_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .station_addr(station_addr), .tx_start(tx_start), .tx_len(tx_len),
        .tx_done(tx_done), .rx_start(rx_start), .rx_done(rx_done),
        .rx_len_in(rx_len_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
        logic [7:0]  req;
    } vec_t;

    // Write each word, then read it back (R1, R4, R7, R8 readback widths).
    localparam vec_t VECS [7] = '{
        '{3'd0, 32'h4433_2211, 32'h4433_2211, 8'd1},
        '{3'd1, 32'hFFFF_6655, 32'h0000_6655, 8'd1},
        '{3'd5, 32'h0000_FFFF, 32'h0000_07FF, 8'd8},
        '{3'd4, 32'h0000_00FF, 32'h0000_0003, 8'd7},
        '{3'd2, 32'h0000_0000, 32'h0000_0000, 8'd4},
        '{3'd6, 32'h0000_0123, 32'h0000_0000, 8'd8},
        '{3'd4, 32'h0000_0000, 32'h0000_0000, 8'd7}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the capturing edge.
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read one word; the side effect takes place at the edge inside the access.
    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_tx;
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx;
        @(negedge clk); rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state.
        bus_read(3'd3, rd);        check("R9 status", rd, 32'h1);
        check("R9 irq", irq, 0);
        check("R9 station", station_addr, 48'h0);
        check("R9 tx_start", tx_start, 0);

        // Vector table walk.
        for (int i = 0; i < 7; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, rd);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].expect_rd);
        end
        check("R1 station order", station_addr, 48'h1122_3344_5566);
        check("R8 tx_len out", tx_len, 11'h7FF);
        bus_read(3'd7, rd);        check("R10 spare word", rd, 32'h0);

        // R2: accepted transmit start.
        bus_write(3'd2, 32'h1);
        check("R2 tx_start high", tx_start, 1);
        @(negedge clk);
        check("R4 tx_start one cycle", tx_start, 0);
        bus_read(3'd3, rd);        check("R2 txr low", rd, 32'h0);

        // R5: start while busy is ignored.
        bus_write(3'd2, 32'h1);
        check("R5 no pulse", tx_start, 0);
        bus_read(3'd3, rd);        check("R5 txr stays low", rd, 32'h0);

        // R2/R6/R7: completion with irq masked.
        pulse_tx();
        @(negedge clk);
        check("R7 masked irq", irq, 0);
        bus_read(3'd3, rd);        check("R6 ready plus flag", rd, 32'h5);
        bus_read(3'd3, rd);        check("R6 read clears", rd, 32'h1);

        // R7: enabled transmit interrupt with one-clock lag.
        bus_write(3'd4, 32'h1);
        pulse_tx();
        check("R7 irq lag", irq, 0);
        @(negedge clk);
        check("R7 irq high", irq, 1);
        bus_read(3'd3, rd);
        check("R7 irq still high", irq, 1);
        @(negedge clk);
        check("R7 irq cleared", irq, 0);

        // R7: receive flag with only transmit enabled stays masked.
        rx_len_in = 11'h40;
        pulse_rx();
        @(negedge clk);
        check("R7 rx masked", irq, 0);
        bus_read(3'd3, rd);        check("R3 status held", rd, 32'hB);
        bus_read(3'd6, rd);        check("R3 rx_len", rd, 32'h40);

        // R3: re-arm clears the frame-held bit and pulses rx_start.
        bus_write(3'd2, 32'h2);
        check("R3 rx_start", rx_start, 1);
        @(negedge clk);
        check("R4 rx_start one cycle", rx_start, 0);
        bus_read(3'd3, rd);        check("R3 rxv cleared", rd, 32'h1);

        // R3: done and re-arm in one cycle -> frame held.
        rx_len_in = 11'h55;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h2; rx_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_done = 1'b0;
        bus_read(3'd3, rd);        check("R3 done wins", rd & 32'h2, 32'h2);

        // R6: done pulse during a status read keeps its flag.
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd3; tx_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; tx_done = 1'b0;
        bus_read(3'd3, rd);        check("R6 set wins", rd & 32'h4, 32'h4);

        // R8: receive length word ignores writes.
        bus_write(3'd6, 32'h7FF);
        bus_read(3'd6, rd);        check("R8 rx_len read-only", rd, 32'h55);

        // R9: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_read(3'd3, rd);        check("R9 status after reset", rd, 32'h1);
        bus_read(3'd4, rd);        check("R9 irq_en", rd, 32'h0);
        bus_read(3'd5, rd);        check("R9 tx_len", rd, 32'h0);
        check("R9 station cleared", station_addr, 48'h0);
        check("R9 irq low", irq, 0);

        finished = 1'b1;
        finish_run();
    end
endmodule